// File: doc/BRIEF.md
# Seven-Slot Pixel Lane Serializer

This block turns one parallel pixel per pixel period into serial bits on up to four data lanes and one lane-clock line. Every pixel period is seven slots long. A slot strobe, pulsed once for each slot by the fast clock domain, moves the sequencer on by one slot. The pixel word is made of 8-bit red, green and blue, sync and enable controls, and one spare control bit. It is captured together with the packing mode only at the strobe that opens slot 0. That strobe opens a frame of seven slots. Changes on the parallel side during the frame do not affect the bits already being sent.

The packing mode picks how colour and control bits are spread over the lanes. The first option is 18-bit colour on three lanes. The second is 24-bit colour on four lanes, where lanes 0 to 2 carry the top six bits of each colour. The third is 24-bit colour on four lanes, where lanes 0 to 2 carry the low six bits and lane 3 carries the top two. The sequencer is a state machine with states `ST_IDLE` and `ST_SL0` to `ST_SL6`. Its transitions are: `ST_IDLE` to `ST_SL0` on the first strobe after reset, `ST_SLk` to `ST_SLk+1` on each strobe, and `ST_SL6` back to `ST_SL0` on a strobe, which is the wrap that captures the next pixel. With no strobe, every state holds.

Top module: `lvds7_serializer`

## Requirements
- R1: After reset, and until the first slot strobe, all lane outputs and the lane clock are low.
- R2: The slot changes only on a cycle with `slot_stb` high. On a cycle with `slot_stb` low, all outputs keep their values.
- R3: The pixel, the control bits and `mode` are captured only by the strobe that starts slot 0. Input changes made after that strobe have no effect on slots 0 to 6 of that frame.
- R4: The lane clock sends 1,1,0,0,0,1,1 over slots 0 to 6, so it falls between slot 1 and slot 2.
- R5: When `mode` = 2'b00 (18-bit), lane 0 sends G0,R5,R4,R3,R2,R1,R0; lane 1 sends B1,B0,G5,G4,G3,G2,G1; lane 2 sends CTL2,CTL1,CTL0,B5,B4,B3,B2 over slots 0 to 6. Lane 3 stays low.
- R6: When `mode` = 2'b01 (24-bit, high bits on lanes 0 to 2), lane 0 sends G2,R7..R2; lane 1 sends B3,B2,G7..G3; lane 2 sends CTL2,CTL1,CTL0,B7..B4.
- R7: When `mode` = 2'b01, lane 3 sends CTL3,B1,B0,G1,G0,R1,R0.
- R8: When `mode` = 2'b10 (24-bit, low bits on lanes 0 to 2), lanes 0 to 2 carry the R5 order using colour bits [5:0].
- R9: When `mode` = 2'b10, lane 3 sends CTL3,B7,B6,G7,G6,R7,R6.
- R10: `mode` = 2'b11 behaves exactly as 2'b00.
- R11: CTL0 is `hsync`, CTL1 is `vsync`, CTL2 is `de` and CTL3 is `ctl_spare`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_stb | input | 1 | One pulse per serial slot |
| mode | input | 2 | Packing mode, captured at slot 0 |
| red | input | 8 | Red component |
| grn | input | 8 | Green component |
| blu | input | 8 | Blue component |
| hsync | input | 1 | Horizontal sync (CTL0) |
| vsync | input | 1 | Vertical sync (CTL1) |
| de | input | 1 | Data enable (CTL2) |
| ctl_spare | input | 1 | Spare control (CTL3) |
| lane_d | output | 4 | Serial data lanes, bit n is lane n |
| lane_clk | output | 1 | Seven-slot lane clock pattern |

## Verification
Two things fall in the same cycle: the wrap from slot 6 to slot 0 that sends out the last bit of one pixel, and the capture of the next pixel and mode. The bench sends pixels back to back, so every wrap strobe is also a capture. Right after each capture it inverts the colour and control inputs and flips the mode. Each slot of the new frame is then compared with values computed from the captured word, so both a late capture and a capture that leaks through would show up. Idle cycles are placed between strobes on alternate pixels to check that the outputs hold.

// File: rtl/lvds7_pkg.sv
package lvds7_pkg;

    localparam int COLOR_W   = 8;
    localparam int CTL_W     = 4;
    localparam int LANES     = 4;
    localparam int SLOTS     = 7;
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int HI_SHIFT  = COLOR_W - 6;
    localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;

    typedef enum logic [1:0] {
        PK_18   = 2'd0,
        PK_24HI = 2'd1,
        PK_24LO = 2'd2,
        PK_RSV  = 2'd3
    } pack_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SL0,
        ST_SL1,
        ST_SL2,
        ST_SL3,
        ST_SL4,
        ST_SL5,
        ST_SL6
    } slot_e;

    typedef struct packed {
        logic [COLOR_W-1:0] r;
        logic [COLOR_W-1:0] g;
        logic [COLOR_W-1:0] b;
        logic [CTL_W-1:0]   ctl;
        pack_e              mode;
    } pixel_t;

    function automatic logic [SLOT_W-1:0] slot_index(slot_e s);
        logic [SLOT_W-1:0] idx;
        unique case (s)
            ST_SL0:  idx = 3'd0;
            ST_SL1:  idx = 3'd1;
            ST_SL2:  idx = 3'd2;
            ST_SL3:  idx = 3'd3;
            ST_SL4:  idx = 3'd4;
            ST_SL5:  idx = 3'd5;
            ST_SL6:  idx = 3'd6;
            default: idx = 3'd0;
        endcase
        return idx;
    endfunction

    // Bit k of the result is the value sent in slot k.
    function automatic logic [SLOTS-1:0] lane_pattern(pixel_t p, int lane);
        logic [COLOR_W-1:0] rs;
        logic [COLOR_W-1:0] gs;
        logic [COLOR_W-1:0] bs;
        logic [SLOTS-1:0]   v;
        if (p.mode == PK_24HI) begin
            rs = p.r >> HI_SHIFT;
            gs = p.g >> HI_SHIFT;
            bs = p.b >> HI_SHIFT;
        end else begin
            rs = p.r;
            gs = p.g;
            bs = p.b;
        end
        case (lane)
            0: v = {rs[0], rs[1], rs[2], rs[3], rs[4], rs[5], gs[0]};
            1: v = {gs[1], gs[2], gs[3], gs[4], gs[5], bs[0], bs[1]};
            2: v = {bs[2], bs[3], bs[4], bs[5], p.ctl[0], p.ctl[1], p.ctl[2]};
            default: begin
                unique case (p.mode)
                    PK_24HI: v = {p.r[0], p.r[1], p.g[0], p.g[1],
                                  p.b[0], p.b[1], p.ctl[3]};
                    PK_24LO: v = {p.r[COLOR_W-2], p.r[COLOR_W-1],
                                  p.g[COLOR_W-2], p.g[COLOR_W-1],
                                  p.b[COLOR_W-2], p.b[COLOR_W-1], p.ctl[3]};
                    PK_18, PK_RSV: v = '0;
                endcase
            end
        endcase
        return v;
    endfunction

endpackage

// File: rtl/lvds7_slot_seq.sv
module lvds7_slot_seq
    import lvds7_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  slot_stb,
    output slot_e state,
    output logic  capture
);

    slot_e state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        capture  = 1'b0;
        if (slot_stb) begin
            unique case (state)
                ST_IDLE: begin state_nx = ST_SL0; capture = 1'b1; end
                ST_SL0:  state_nx = ST_SL1;
                ST_SL1:  state_nx = ST_SL2;
                ST_SL2:  state_nx = ST_SL3;
                ST_SL3:  state_nx = ST_SL4;
                ST_SL4:  state_nx = ST_SL5;
                ST_SL5:  state_nx = ST_SL6;
                ST_SL6:  begin state_nx = ST_SL0; capture = 1'b1; end
            endcase
        end
    end

endmodule

// File: rtl/lvds7_pix_capture.sv
module lvds7_pix_capture
    import lvds7_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   capture,
    input  pixel_t pix_in,
    output pixel_t pix_held
);

    always_ff @(posedge clk) begin
        if (!rst_n)       pix_held <= '0;
        else if (capture) pix_held <= pix_in;
    end

endmodule

// File: rtl/lvds7_lane_map.sv
module lvds7_lane_map
    import lvds7_pkg::*;
(
    input  slot_e              state,
    input  pixel_t             pix_held,
    output logic [LANES-1:0]   lane_d
);

    logic [SLOTS-1:0]  vecs [LANES];
    logic [SLOT_W-1:0] idx;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign vecs[i] = lane_pattern(pix_held, i);
    end

    assign idx = slot_index(state);

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            unique case (state)
                ST_IDLE: lane_d[i] = 1'b0;
                default: lane_d[i] = vecs[i][idx];
            endcase
        end
    end

endmodule

// File: rtl/lvds7_clk_pattern.sv
module lvds7_clk_pattern
    import lvds7_pkg::*;
#(
    parameter logic [SLOTS-1:0] PATTERN = CLK_PATTERN
) (
    input  slot_e state,
    output logic  lane_clk
);

    always_comb begin
        unique case (state)
            ST_IDLE: lane_clk = 1'b0;
            default: lane_clk = PATTERN[slot_index(state)];
        endcase
    end

endmodule

// File: rtl/lvds7_serializer.sv
module lvds7_serializer
    import lvds7_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slot_stb,
    input  logic [1:0]         mode,
    input  logic [COLOR_W-1:0] red,
    input  logic [COLOR_W-1:0] grn,
    input  logic [COLOR_W-1:0] blu,
    input  logic               hsync,
    input  logic               vsync,
    input  logic               de,
    input  logic               ctl_spare,
    output logic [LANES-1:0]   lane_d,
    output logic               lane_clk
);

    slot_e  state;
    logic   capture;
    pixel_t pix_in;
    pixel_t pix_held;

    assign pix_in = '{r: red, g: grn, b: blu,
                      ctl: {ctl_spare, de, vsync, hsync},
                      mode: pack_e'(mode)};

    lvds7_slot_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_stb (slot_stb),
        .state    (state),
        .capture  (capture)
    );

    lvds7_pix_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (capture),
        .pix_in   (pix_in),
        .pix_held (pix_held)
    );

    lvds7_lane_map u_map (
        .state    (state),
        .pix_held (pix_held),
        .lane_d   (lane_d)
    );

    lvds7_clk_pattern #(.PATTERN(CLK_PATTERN)) u_clk (
        .state    (state),
        .lane_clk (lane_clk)
    );

endmodule

// File: rtl/lvds7_serializer_chk.sv
module lvds7_serializer_chk
    import lvds7_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             slot_stb,
    input logic [1:0]       mode,
    input logic             de,
    input logic [LANES-1:0] lane_d,
    input logic             lane_clk
);

    logic              started;
    logic [SLOT_W-1:0] phase;
    logic [1:0]        cap_mode;
    logic              cap_de;
    logic              take;

    assign take = slot_stb && (!started || phase == SLOT_W'(SLOTS-1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started  <= 1'b0;
            phase    <= '0;
            cap_mode <= '0;
            cap_de   <= 1'b0;
        end else if (slot_stb) begin
            started <= 1'b1;
            phase   <= take ? '0 : phase + 1'b1;
            if (take) begin
                cap_mode <= mode;
                cap_de   <= de;
            end
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !started |-> (lane_d == '0 && !lane_clk));

    p_hold_no_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_stb |=> ($stable(lane_d) && $stable(lane_clk)));

    p_clk_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> (lane_clk == CLK_PATTERN[phase]));

    // R5 and R10: lane 3 idles in the three-lane packings
    p_lane3_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (started && (cap_mode == 2'd0 || cap_mode == 2'd3)) |-> !lane_d[3]);

    p_de_slot0_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (started && phase == '0) |-> (lane_d[2] == cap_de));

endmodule

bind lvds7_serializer lvds7_serializer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .slot_stb (slot_stb),
    .mode     (mode),
    .de       (de),
    .lane_d   (lane_d),
    .lane_clk (lane_clk)
);

// File: tb/sim_lvds7_serializer.sv
module sim_lvds7_serializer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       slot_stb;
    logic [1:0] mode;
    logic [7:0] red, grn, blu;
    logic       hsync, vsync, de, ctl_spare;
    logic [3:0] lane_d;
    logic       lane_clk;

    int checks = 0;
    int errors = 0;

    // 4 time units per period: 250 MHz with 1 ns units
    always #2 clk = ~clk;

    lvds7_serializer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_stb  (slot_stb),
        .mode      (mode),
        .red       (red),
        .grn       (grn),
        .blu       (blu),
        .hsync     (hsync),
        .vsync     (vsync),
        .de        (de),
        .ctl_spare (ctl_spare),
        .lane_d    (lane_d),
        .lane_clk  (lane_clk)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected lanes for slot s, computed per slot from the requirement text.
    function automatic logic [3:0] exp_lanes(int m, int s, logic [7:0] r,
                                             logic [7:0] g, logic [7:0] b,
                                             logic [3:0] c);
        int o;
        int base;
        logic l0, l1, l2, l3;
        o = (m == 1) ? 2 : 0;
        l0 = (s == 0) ? g[o] : r[o + 6 - s];
        l1 = (s == 0) ? b[o + 1] : (s == 1) ? b[o] : g[o + 7 - s];
        l2 = (s <= 2) ? c[2 - s] : b[o + 8 - s];
        if (m == 1 || m == 2) begin
            base = (m == 1) ? 0 : 6;
            case (s)
                0: l3 = c[3];
                1: l3 = b[base + 1];
                2: l3 = b[base];
                3: l3 = g[base + 1];
                4: l3 = g[base];
                5: l3 = r[base + 1];
                default: l3 = r[base];
            endcase
        end else begin
            l3 = 1'b0;
        end
        return {l3, l2, l1, l0};
    endfunction

    function automatic string tag_low(int m);
        case (m)
            0: return "R5";
            1: return "R6";
            2: return "R8";
            default: return "R10";
        endcase
    endfunction

    function automatic string tag_l3(int m);
        case (m)
            0: return "R5";
            1: return "R7";
            2: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic send_pixel(input int m, input logic [27:0] w, input bit gap);
        logic [7:0] r, g, b;
        logic [3:0] c;
        logic [3:0] e;
        logic [6:0] clkpat;
        logic [3:0] held_d;
        logic       held_c;
        r = w[7:0];
        g = w[15:8];
        b = w[23:16];
        c = w[27:24];
        clkpat = 7'b1100011;
        for (int s = 0; s < 7; s++) begin
            if (s == 0) begin
                mode = 2'(m);
                red = r; grn = g; blu = b;
                {ctl_spare, de, vsync, hsync} = c;
            end
            slot_stb = 1'b1;
            @(posedge clk);
            @(negedge clk);
            slot_stb = 1'b0;
            if (s == 0) begin
                // R3: disturb every captured input right after capture
                mode = 2'(m) ^ 2'b01;
                red = ~r; grn = ~g; blu = ~b;
                {ctl_spare, de, vsync, hsync} = ~c;
            end
            e = exp_lanes(m, s, r, g, b, c);
            chk(lane_d[2:0] == e[2:0], tag_low(m), 8'(lane_d[2:0]), 8'(e[2:0]));
            chk(lane_d[3] == e[3], tag_l3(m), 8'(lane_d[3]), 8'(e[3]));
            chk(lane_clk == clkpat[s], "R4", 8'(lane_clk), 8'(clkpat[s]));
            if (s <= 2)
                chk(lane_d[2] == c[2 - s], "R11", 8'(lane_d[2]), 8'(c[2 - s]));
            if (s == 0 && m == 1)
                chk(lane_d[3] == c[3], "R11", 8'(lane_d[3]), 8'(c[3]));
            if (s == 6)
                chk(lane_d == e, "R3", 8'(lane_d), 8'(e));
            if (gap) begin
                held_d = lane_d;
                held_c = lane_clk;
                red = ~red;
                @(negedge clk);
                chk(lane_d == held_d && lane_clk == held_c, "R2",
                    8'({lane_clk, lane_d}), 8'({held_c, held_d}));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [27:0] w;
        rst_n = 1'b0;
        slot_stb = 1'b0;
        mode = 2'd0;
        red = 8'hff; grn = 8'hff; blu = 8'hff;
        hsync = 1'b1; vsync = 1'b1; de = 1'b1; ctl_spare = 1'b1;
        repeat (3) @(negedge clk);
        chk(lane_d == 4'd0 && !lane_clk, "R1", 8'({lane_clk, lane_d}), 8'h00);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(lane_d == 4'd0 && !lane_clk, "R1", 8'({lane_clk, lane_d}), 8'h00);

        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 30; k++) begin
                if (k < 28)       w = 28'(1) << k;
                else if (k == 28) w = '1;
                else              w = 28'h9a5c36e;
                send_pixel(m, w, k[0]);
            end
        end
        // back-to-back mode switches with mixed words
        for (int k = 0; k < 8; k++) begin
            send_pixel(k % 4, 28'h6d2b1f3 ^ (28'h1111111 * k), 1'b0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule